// File: doc/BRIEF.md
# Interval Timer Channel

This block is one down-counting interval timer channel that sits in a four-channel bank. It counts an external 1 µs tick pulse, which is generated elsewhere and arrives as a single-cycle strobe. Software programs the channel through two 32-bit registers. The control register holds the enable flag, the periodic-mode flag and a 29-bit reload count equal to the interval minus one. The status register reports the pending interrupt and the live counter value. The status register also acknowledges the interrupt when software writes a word with the acknowledge bit set.

The bank decode is part of the block. A parameter picks which of the four channel slots the instance occupies. The instance answers only at its own slot's two addresses and ignores all other bus traffic. In one-shot mode the channel disables itself when it expires. In periodic mode it reloads on the expiry tick and keeps running. The interrupt output is a level, active high, and stays asserted until software acknowledges it.

The channel is built around a three-state machine:
- **IDLE**: stopped.
- **ONESHOT**: running and will stop at expiry.
- **PERIODIC**: running and reloads at expiry.

The transitions are:
- **start_once**: IDLE or any state to ONESHOT, on a control write with enable set and periodic clear.
- **start_loop**: to PERIODIC, on a control write with both enable and periodic set.
- **halt**: to IDLE, on a control write with enable clear.
- **expire_stop**: ONESHOT to IDLE, on a tick while the counter is zero.
- **expire_reload**: PERIODIC to PERIODIC, on a tick while the counter is zero.

Top module: `tmr_chan`

## Requirements
- R1: After reset the interrupt output is low. Both the control register and the status register read as zero.
- R2: The channel slot index 0, 1, 2 or 3 places the channel base at 0x00, 0x08, 0x50 or 0x58. The control register sits at base+0 and the status register at base+4. At any other address, writes have no effect on this channel and reads return zero.
- R3: The control register uses these bits, and it reads back with the same layout:
  - bit 31 is enable (1 = running);
  - bit 30 is periodic mode (1 = periodic);
  - bits [28:0] are the reload count.
  The full reload count 0x1FFFFFFF is accepted.
- R4: In one-shot mode, a reload count of N−1 raises the interrupt on the N-th tick after the write. At that point enable (bit 31) reads back 0. A reload count of 0 expires on the first tick.
- R5: In periodic mode, the counter reloads from the stored count on the expiry tick. The interrupt is raised once every N ticks for a count of N−1.
- R6: Writing zero to the control register stops the channel. The counter then stays at zero and no interrupt is raised.
- R7: Writing the status register with bit 30 set clears the interrupt. A status write with bit 30 clear leaves the interrupt unchanged.
- R8: A control write while the channel runs loads the counter with the new count at once. The interval restarts from that count.
- R9: Reading the status register returns the pending flag in bit 30 and the live counter in bits [28:0].
- R10: When an expiry and an acknowledge fall in the same cycle, the interrupt stays set.
- R11: While the channel is stopped, ticks leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle 1 µs count strobe |
| we | input | 1 | Register write strobe |
| addr | input | ADDR_W (8) | Bank byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench builds the channel with slot index 2, so its registers sit at 0x50 and 0x54. With that placement, writes aimed at slot 0 (0x00) and slot 3 (0x58) show that the decode rejects neighbouring channels. The count width stays at its default of 29 bits. This lets the bench check the widest reload value for readback, while short intervals of one to eleven ticks cover expiry, periodic reload, a restart in mid-interval, and an acknowledge that lands on the same cycle as an expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W  = 32;
    localparam int BIT_EN  = 31;
    localparam int BIT_PER = 30;
    localparam int BIT_ACK = 30;
    localparam int BIT_PND = 30;
    localparam int OFS_CTL = 0;
    localparam int OFS_STS = 4;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ONESHOT  = 2'd1,
        ST_PERIODIC = 2'd2
    } tmr_state_t;

    function automatic int slot_base(input int idx);
        return ((idx & 2) != 0 ? 'h50 : 0) + ((idx & 1) != 0 ? 'h08 : 0);
    endfunction
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SLOT   = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              ctl_hit,
    output logic              sts_hit
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(slot_base(SLOT));
    localparam logic [ADDR_W-1:0] CTL_A = BASE + ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] STS_A = BASE + ADDR_W'(OFS_STS);

    always_comb begin
        ctl_hit = (addr == CTL_A);
        sts_hit = (addr == STS_A);
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctl_we,
    input  logic             ack_we,
    input  logic [DATA_W-1:0] wdata,
    output logic             running,
    output logic             periodic,
    output logic             pending,
    output logic             expire,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload
);
    tmr_state_t state, state_nx;
    logic       at_zero;

    always_comb begin
        at_zero = (count == '0);
        expire  = (state != ST_IDLE) && tick && at_zero && !ctl_we;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (ctl_we) begin
            if (!wdata[BIT_EN])       state_nx = ST_IDLE;      // halt
            else if (wdata[BIT_PER])  state_nx = ST_PERIODIC;  // start_loop
            else                      state_nx = ST_ONESHOT;   // start_once
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ONESHOT:  if (expire) state_nx = ST_IDLE;   // expire_stop
                ST_PERIODIC: state_nx = ST_PERIODIC;           // expire_reload
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // counter, stored fields and pending flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            reload   <= '0;
            periodic <= 1'b0;
            pending  <= 1'b0;
        end else begin
            if (ctl_we) begin
                reload   <= wdata[CNT_W-1:0];
                count    <= wdata[CNT_W-1:0];
                periodic <= wdata[BIT_PER];
            end else if (state != ST_IDLE && tick) begin
                if (at_zero) count <= (state == ST_PERIODIC) ? reload : '0;
                else         count <= count - 1'b1;
            end
            if (expire)                         pending <= 1'b1;
            else if (ack_we && wdata[BIT_ACK])  pending <= 1'b0;
        end
    end

    always_comb running = (state != ST_IDLE);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SLOT   = 0,
    parameter int CNT_W  = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);
    logic             ctl_hit, sts_hit;
    logic             running, periodic, pending, expire;
    logic [CNT_W-1:0] count, reload;
    logic [31:0]      ctl_view, sts_view;

    tmr_decode #(.ADDR_W(ADDR_W), .SLOT(SLOT)) u_dec (
        .addr    (addr),
        .ctl_hit (ctl_hit),
        .sts_hit (sts_hit)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ctl_we   (we && ctl_hit),
        .ack_we   (we && sts_hit),
        .wdata    (wdata),
        .running  (running),
        .periodic (periodic),
        .pending  (pending),
        .expire   (expire),
        .count    (count),
        .reload   (reload)
    );

    always_comb begin
        ctl_view = '0;
        ctl_view[CNT_W-1:0] = reload;
        ctl_view[BIT_EN]    = running;
        ctl_view[BIT_PER]   = periodic;
        sts_view = '0;
        sts_view[CNT_W-1:0] = count;
        sts_view[BIT_PND]   = pending;
        if (ctl_hit)      rdata = ctl_view;
        else if (sts_hit) rdata = sts_view;
        else              rdata = '0;
        irq = pending;
    end
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
    parameter int CNT_W = 29
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             we,
    input logic [31:0]      wdata,
    input logic             irq,
    input logic             ctl_hit,
    input logic             sts_hit,
    input logic             running,
    input logic             periodic,
    input logic             expire,
    input logic [CNT_W-1:0] count
);
    // R4
    irq_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick));

    // R7
    irq_fall_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(we && sts_hit && wdata[30]));

    // R6
    halt_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ctl_hit && !wdata[31]) |=> !running);

    // R11
    idle_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(we && ctl_hit)) |=> $stable(count));

    // R5
    periodic_keeps_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && periodic && expire) |=> running);

    // R10
    expire_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq);
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .we       (we),
    .wdata    (wdata),
    .irq      (irq),
    .ctl_hit  (ctl_hit),
    .sts_hit  (sts_hit),
    .running  (running),
    .periodic (periodic),
    .expire   (expire),
    .count    (count)
);

// File: tb/sim_tmr_chan.sv
module sim_tmr_chan;
    localparam int ADDR_W = 8;
    localparam logic [7:0] CTL = 8'h50;
    localparam logic [7:0] STS = 8'h54;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_chan #(.ADDR_W(ADDR_W), .SLOT(2), .CNT_W(29)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic ack();
        wr(STS, 32'h4000_0000);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(CTL, v); chk("R1 ctl", v, 0);
        rd(STS, v); chk("R1 sts", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_layout();
        logic [31:0] v;
        wr(CTL, 32'h5FFF_FFFF);
        rd(CTL, v); chk("R3 max reload readback", v, 32'h5FFF_FFFF);
        rd(STS, v); chk("R9 count field", v, 32'h1FFF_FFFF);
        wr(CTL, 32'h0000_0000);
    endtask

    task automatic t_decode();
        logic [31:0] v;
        wr(CTL, 32'h0000_0123);
        wr(8'h00, 32'h8000_0004);
        rd(8'h00, v); chk("R2 foreign read", v, 0);
        wr(8'h58, 32'hC000_0001);
        wr(8'h5C, 32'h4000_0000);
        rd(CTL, v); chk("R2 own reg unchanged", v, 32'h0000_0123);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(CTL, 32'h8000_0003);
        ticks(3);
        rd(STS, v); chk("R4 before expiry", v, 32'h0000_0000);
        chk("R4 irq low at tick 3", {31'b0, irq}, 0);
        ticks(1);
        chk("R4 irq at tick 4", {31'b0, irq}, 1);
        rd(CTL, v); chk("R4 enable self-clear", v, 32'h0000_0003);
        rd(STS, v); chk("R9 pending bit", v, 32'h4000_0000);
        ticks(2);
        rd(STS, v); chk("R11 idle count hold", v, 32'h4000_0000);
        wr(STS, 32'hBFFF_FFFF);
        chk("R7 no ack without bit30", {31'b0, irq}, 1);
        ack();
        chk("R7 ack clears", {31'b0, irq}, 0);
        wr(CTL, 32'h8000_0000);
        ticks(1);
        chk("R4 zero count one tick", {31'b0, irq}, 1);
        ack();
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(CTL, 32'hC000_0002);
        ticks(3);
        chk("R5 first expiry", {31'b0, irq}, 1);
        rd(STS, v); chk("R5 reloaded", v, 32'h4000_0002);
        ack();
        ticks(2);
        chk("R5 no early irq", {31'b0, irq}, 0);
        ticks(1);
        chk("R5 second expiry", {31'b0, irq}, 1);
        rd(CTL, v); chk("R5 still enabled", v, 32'hC000_0002);
        ack();
    endtask

    task automatic t_stop();
        logic [31:0] v;
        wr(CTL, 32'hC000_0009);
        ticks(2);
        rd(STS, v); chk("R9 live count", v, 32'h0000_0007);
        wr(CTL, 32'h0);
        ticks(4);
        rd(STS, v); chk("R6 stopped count", v, 0);
        chk("R6 no irq", {31'b0, irq}, 0);
        wr(CTL, 32'h0000_0007);
        ticks(3);
        rd(STS, v); chk("R11 disabled hold", v, 32'h0000_0007);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        wr(CTL, 32'h8000_000A);
        ticks(3);
        rd(STS, v); chk("R8 before rewrite", v, 32'h0000_0007);
        wr(CTL, 32'h8000_0005);
        rd(STS, v); chk("R8 reloaded now", v, 32'h0000_0005);
        ticks(5);
        chk("R8 not yet", {31'b0, irq}, 0);
        ticks(1);
        chk("R8 expiry after new interval", {31'b0, irq}, 1);
        ack();
    endtask

    task automatic t_collide();
        wr(CTL, 32'h8000_0000);
        @(negedge clk); we = 1'b1; addr = STS; wdata = 32'h4000_0000; tick = 1'b1;
        @(negedge clk); we = 1'b0; tick = 1'b0;
        chk("R10 expire beats ack", {31'b0, irq}, 1);
        ack();
        chk("R10 later ack clears", {31'b0, irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_decode();
        t_oneshot();
        t_periodic();
        t_stop();
        t_restart();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule